// File: doc/BRIEF.md
# Interleaved Memory Decoder Target Selector

This block is a bank of programmable address-range decoders. Each decoder covers a window of host physical address space and spreads it across up to eight downstream ports. Software programs the bank through a 32-bit word-addressed write port. The routing logic then presents a lookup address. One cycle later the block returns the 8-bit port number that owns that address, together with a found flag.

Each decoder has a base, a size, a control word and a target list of eight byte-wide entries. Base and size are kept in 256 MiB units. The control word holds a committed flag, an interleave-ways code and an interleave-granularity code. A capability word tells the block how many decoders are in use. The decoders are tried in index order, and only the first one whose window holds the address decides the result. If that decoder has not been committed, the lookup misses, even when a later decoder also covers the address.

Top module: `ilv_target_sel`

## Requirements
- R1: After synchronous reset, rsp_valid, rsp_found and rsp_target are 0 and every register is 0, so any lookup misses.
- R2: A lookup presented with lk_valid high returns rsp_valid high on the next cycle. In a cycle after lk_valid was low, rsp_valid, rsp_found and rsp_target are all 0.
- R3: Bits [3:0] of register word 0 give the number of decoders in use. Only decoders with index below that number take part, and values above NUM_DEC act as NUM_DEC.
- R4: A decoder's base is {base_hi[31:0], base_lo[31:28]} << 28 and its size is {size_hi[31:0], size_lo[31:28]} << 28. Bits 27:0 of the low words have no effect.
- R5: A decoder hits when base <= address < base + size. A window that reaches 2^64 still covers the top address, and a size of zero never hits.
- R6: When several windows hold the address, the hitting decoder with the lowest index decides the result.
- R7: If the first hitting decoder has its committed bit (ctrl bit 8) clear, the result is a miss, and later decoders are not tried.
- R8: The interleave index is (address >> (8 + g)) mod 2^w. Here g is ctrl[3:0] and w is ctrl[5:4].
- R9: Index k in 0..3 returns byte k of tgt_lo, meaning bits [8k+7:8k]. Index k in 4..7 returns byte k-4 of tgt_hi.
- R10: When no decoder in use holds the address, or on R7, rsp_found is 0 and rsp_target is 0.
- R11: Register word 0 is the capability word. Decoder i (from 0) sits at words 8*(i+1) to 8*(i+1)+6, in this order: base_lo, base_hi, size_lo, size_hi, ctrl, tgt_lo, tgt_hi. Writes to any other word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Register word address |
| wr_data | input | 32 | Register write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_found | output | 1 | A committed decoder owns the address |
| rsp_target | output | 8 | Selected port number |

## Verification
The hardest case to reach is an uncommitted decoder whose window hides a committed decoder further down the list. The stimulus sets this up with two decoders that share a base. The smaller, uncommitted one comes first, so addresses in the shared part must miss, and only addresses past its end may reach the committed one. A window that ends exactly at 2^64 checks the carry in the end comparison. Rewriting the count field, the low bits of the size word and unmapped words between lookups checks that only what the requirements name affects the result.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Word offsets inside one decoder's register slot (stride 8 words).
  localparam int OFS_BASE_LO = 0;
  localparam int OFS_BASE_HI = 1;
  localparam int OFS_SIZE_LO = 2;
  localparam int OFS_SIZE_HI = 3;
  localparam int OFS_CTRL    = 4;
  localparam int OFS_TGT_LO  = 5;
  localparam int OFS_TGT_HI  = 6;
  localparam int SLOT_SHIFT  = 3;

  // Control word fields.
  localparam int CTRL_GRAN_LSB = 0;
  localparam int CTRL_GRAN_W   = 4;
  localparam int CTRL_WAYS_LSB = 4;
  localparam int CTRL_WAYS_W   = 2;
  localparam int CTRL_COMMIT   = 8;

  // Capability word count field width.
  localparam int CNT_W = 4;

  // Window resolution: 256 MiB.
  localparam int WIN_SHIFT  = 28;
  // Smallest interleave granule: 256 bytes.
  localparam int GRAN_SHIFT = 8;

  typedef struct packed {
    logic [31:0] base_lo;
    logic [31:0] base_hi;
    logic [31:0] size_lo;
    logic [31:0] size_hi;
    logic [31:0] ctrl;
    logic [31:0] tgt_lo;
    logic [31:0] tgt_hi;
  } dec_regs_t;

endpackage

// File: rtl/ilv_regfile.sv
module ilv_regfile
  import ilv_pkg::*;
#(
  parameter int NUM_DEC = 8,
  parameter int REG_AW  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       cap_q,
  output dec_regs_t         dec_q [NUM_DEC]
);

  localparam int SLOT_W = REG_AW - SLOT_SHIFT;

  logic [SLOT_W-1:0]     slot;
  logic [SLOT_SHIFT-1:0] ofs;

  assign slot = wr_addr[REG_AW-1:SLOT_SHIFT];
  assign ofs  = wr_addr[SLOT_SHIFT-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
    end else if (wr_en && wr_addr == '0) begin
      cap_q <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (slot == SLOT_W'(g + 1));

    always_ff @(posedge clk) begin
      if (rst) begin
        dec_q[g] <= '0;
      end else if (sel) begin
        case (int'(ofs))
          OFS_BASE_LO: dec_q[g].base_lo <= wr_data;
          OFS_BASE_HI: dec_q[g].base_hi <= wr_data;
          OFS_SIZE_LO: dec_q[g].size_lo <= wr_data;
          OFS_SIZE_HI: dec_q[g].size_hi <= wr_data;
          OFS_CTRL:    dec_q[g].ctrl    <= wr_data;
          OFS_TGT_LO:  dec_q[g].tgt_lo  <= wr_data;
          OFS_TGT_HI:  dec_q[g].tgt_hi  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // R11: a write to word 0 lands in the capability word
  a_r11_cap_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '0) |=> (cap_q == $past(wr_data)));

endmodule

// File: rtl/ilv_dec_eval.sv
module ilv_dec_eval
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  dec_regs_t         regs,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              committed,
  output logic [7:0]        target
);

  localparam int GR_W = ADDR_W - WIN_SHIFT;

  logic [GR_W-1:0]        base_g;
  logic [GR_W-1:0]        size_g;
  logic [GR_W:0]          end_g;
  logic [GR_W-1:0]        addr_g;
  logic [CTRL_GRAN_W-1:0] gran;
  logic [CTRL_WAYS_W-1:0] ways;
  logic [ADDR_W-1:0]      shifted;
  logic [2:0]             way_mask;
  logic [2:0]             idx;
  logic [31:0]            list_word;

  // Window bounds in 256 MiB units; low 28 bits of the low words dropped.
  assign base_g = GR_W'({regs.base_hi, regs.base_lo[31:WIN_SHIFT]});
  assign size_g = GR_W'({regs.size_hi, regs.size_lo[31:WIN_SHIFT]});
  assign end_g  = {1'b0, base_g} + {1'b0, size_g};
  assign addr_g = addr[ADDR_W-1:WIN_SHIFT];

  assign hit = en && (addr_g >= base_g) && ({1'b0, addr_g} < end_g);
  assign committed = regs.ctrl[CTRL_COMMIT];

  assign gran = regs.ctrl[CTRL_GRAN_LSB +: CTRL_GRAN_W];
  assign ways = regs.ctrl[CTRL_WAYS_LSB +: CTRL_WAYS_W];

  assign shifted  = addr >> (GRAN_SHIFT + int'(gran));
  assign way_mask = ~(3'b111 << ways);
  assign idx      = shifted[2:0] & way_mask;

  assign list_word = idx[2] ? regs.tgt_hi : regs.tgt_lo;
  assign target    = list_word[{idx[1:0], 3'b000} +: 8];

endmodule

// File: rtl/ilv_first_hit.sv
module ilv_first_hit #(
  parameter int NUM_DEC = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEC-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic [NUM_DEC-1:0] grant
);

  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = NUM_DEC - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = IDX_W'(i);
        grant = NUM_DEC'(1) << i;
      end
    end
  end

  assign any = |req;

  // R6: at most one decoder decides, and only one that hit
  a_r6_single_winner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~req) == '0));

  // R6: the winner has no lower-indexed hitting decoder
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    any |-> ((req & (grant - NUM_DEC'(1))) == '0));

endmodule

// File: rtl/ilv_target_sel.sv
module ilv_target_sel
  import ilv_pkg::*;
#(
  parameter int NUM_DEC = 8,
  parameter int ADDR_W  = 64,
  parameter int REG_AW  = $clog2(8 * (NUM_DEC + 1))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rsp_valid,
  output logic              rsp_found,
  output logic [7:0]        rsp_target
);

  localparam int IDX_W = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1;

  logic [31:0]        cap_q;
  dec_regs_t          dec_q [NUM_DEC];
  logic [CNT_W-1:0]   cnt_raw;
  logic [CNT_W:0]     cnt_use;
  logic [NUM_DEC-1:0] en_vec;
  logic [NUM_DEC-1:0] hit_vec;
  logic [NUM_DEC-1:0] com_vec;
  logic [7:0]         tgt_arr [NUM_DEC];
  logic               any_hit;
  logic [IDX_W-1:0]   win_idx;
  logic [NUM_DEC-1:0] win_grant;
  logic               nxt_found;
  logic [7:0]         nxt_target;

  ilv_regfile #(
    .NUM_DEC (NUM_DEC),
    .REG_AW  (REG_AW)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cap_q   (cap_q),
    .dec_q   (dec_q)
  );

  // Decoders in use: the count field, saturated at the bank size.
  assign cnt_raw = cap_q[CNT_W-1:0];
  assign cnt_use = ({1'b0, cnt_raw} > (CNT_W+1)'(NUM_DEC)) ?
                   (CNT_W+1)'(NUM_DEC) : {1'b0, cnt_raw};

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
    assign en_vec[g] = ((CNT_W+1)'(g) < cnt_use);

    ilv_dec_eval #(
      .ADDR_W (ADDR_W)
    ) u_eval (
      .regs      (dec_q[g]),
      .en        (en_vec[g]),
      .addr      (lk_addr),
      .hit       (hit_vec[g]),
      .committed (com_vec[g]),
      .target    (tgt_arr[g])
    );
  end

  ilv_first_hit #(
    .NUM_DEC (NUM_DEC),
    .IDX_W   (IDX_W)
  ) u_pick (
    .clk   (clk),
    .rst   (rst),
    .req   (hit_vec),
    .any   (any_hit),
    .idx   (win_idx),
    .grant (win_grant)
  );

  assign nxt_found  = any_hit && com_vec[win_idx];
  assign nxt_target = nxt_found ? tgt_arr[win_idx] : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_found  <= 1'b0;
      rsp_target <= 8'h00;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_found  <= lk_valid && nxt_found;
      rsp_target <= lk_valid ? nxt_target : 8'h00;
    end
  end

  // R2: every request is answered on the next cycle
  a_r2_answer_next: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  // R2: outputs are quiet after an idle cycle
  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!rsp_valid && !rsp_found && rsp_target == 8'h00));

  // R10: a miss carries a zero target
  a_r10_miss_zero: assert property (@(posedge clk) disable iff (rst)
    !rsp_found |-> (rsp_target == 8'h00));

  // R3: with no decoder in use nothing is found
  a_r3_none_in_use: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && cap_q[CNT_W-1:0] == '0) |=> !rsp_found);

  // R7: a winner that is not committed never yields found
  a_r7_uncommitted_miss: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && any_hit && !com_vec[win_idx]) |=> !rsp_found);

endmodule

// File: tb/ilv_target_sel_bench.sv
module ilv_target_sel_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_DEC    = 8;
  localparam int ADDR_W     = 64;
  localparam int REG_AW     = $clog2(8 * (NUM_DEC + 1));
  localparam int NV         = 21;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [REG_AW-1:0] wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic              lk_valid = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic              rsp_valid;
  logic              rsp_found;
  logic [7:0]        rsp_target;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ilv_target_sel #(
    .NUM_DEC (NUM_DEC),
    .ADDR_W  (ADDR_W)
  ) u_ilv_target_sel (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .lk_valid   (lk_valid),
    .lk_addr    (lk_addr),
    .rsp_valid  (rsp_valid),
    .rsp_found  (rsp_found),
    .rsp_target (rsp_target)
  );

  // {address, expected found, expected target}; cap count is 7.
  localparam logic [72:0] VEC [NV] = '{
    {64'h0000_0001_0000_0000, 1'b1, 8'h11},  // R8 R9 index 0
    {64'h0000_0001_0000_0300, 1'b1, 8'h44},  // R8 index 3
    {64'h0000_0001_0000_0500, 1'b1, 8'h22},  // R8 index 1 (wraps mod 4)
    {64'h0000_0001_0000_06FF, 1'b1, 8'h33},  // R9 index 2
    {64'h0000_0001_3FFF_FFFF, 1'b1, 8'h44},  // R5 last byte, R6 dec0 over dec1
    {64'h0000_0001_3000_0000, 1'b1, 8'h11},  // R6 overlap, lower index wins
    {64'h0000_0001_4000_0000, 1'b1, 8'h5A},  // R5 end exclusive, dec1 takes it
    {64'h0000_0001_5FFF_FFFF, 1'b1, 8'h5A},  // R5 dec1 last byte
    {64'h0000_0001_6000_0000, 1'b0, 8'h00},  // R10 past every window
    {64'h0000_0000_FFFF_FFFF, 1'b0, 8'h00},  // R5 below base
    {64'h0000_0002_0000_0000, 1'b0, 8'h00},  // R7 uncommitted dec2 shadows dec3
    {64'h0000_0002_0FFF_FFFF, 1'b0, 8'h00},  // R7 still shadowed
    {64'h0000_0002_1000_0000, 1'b1, 8'h99},  // R7 past dec2, dec3 answers
    {64'h0000_0003_0000_1C00, 1'b1, 8'hA7},  // R8 gran 1 KiB, index 7, R9 hi
    {64'h0000_0003_0000_0400, 1'b1, 8'hA1},  // R8 index 1
    {64'h0000_0003_0000_1000, 1'b1, 8'hA4},  // R9 index 4, hi byte 0
    {64'h0000_0003_0000_0BFF, 1'b1, 8'hA2},  // R8 index 2
    {64'h0000_0003_0000_03FF, 1'b1, 8'hA0},  // R8 inside first granule
    {64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 8'h6C},  // R5 window reaching 2^64
    {64'hFFFF_FFFF_EFFF_FFFF, 1'b0, 8'h00},  // R5 just below top window
    {64'h0000_0000_0000_0000, 1'b0, 8'h00}   // R5 zero-size dec5 never hits
  };

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = REG_AW'(a);
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic prog_dec(input int i, input logic [31:0] blo, input logic [31:0] bhi,
                          input logic [31:0] slo, input logic [31:0] shi,
                          input logic [31:0] ctl, input logic [31:0] tlo,
                          input logic [31:0] thi);
    int b;
    b = 8 * (i + 1);
    wr(b + 0, blo);
    wr(b + 1, bhi);
    wr(b + 2, slo);
    wr(b + 3, shi);
    wr(b + 4, ctl);
    wr(b + 5, tlo);
    wr(b + 6, thi);
  endtask

  task automatic look(input logic [63:0] a, input logic ef, input logic [7:0] et,
                      input string req);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_addr  = a;
    @(negedge clk);
    lk_valid = 1'b0;
    check(rsp_valid == 1'b1, {req, " valid (R2)"}, 64'(rsp_valid), 64'd1);
    check(rsp_found == ef && rsp_target == et, {req, " result"},
          {55'd0, rsp_found, rsp_target}, {55'd0, ef, et});
    @(negedge clk);
    check(!rsp_valid && !rsp_found && rsp_target == 8'h00, "R2 idle after lookup",
          {55'd0, rsp_valid, rsp_target}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    check(!rsp_valid && !rsp_found && rsp_target == 8'h00, "R1 reset outputs",
          {55'd0, rsp_valid, rsp_target}, 64'd0);
    look(64'h0000_0001_0000_0000, 1'b0, 8'h00, "R1 empty bank");

    // Low base bits are junk on purpose (R4).
    prog_dec(0, 32'h0ABC_DEF0, 32'h1, 32'h4000_0000, 32'h0,
             32'h0000_0120, 32'h4433_2211, 32'h8877_6655);
    prog_dec(1, 32'h2000_0000, 32'h1, 32'h4000_0000, 32'h0,
             32'h0000_0100, 32'h0000_005A, 32'h0);
    prog_dec(2, 32'h0000_0000, 32'h2, 32'h1000_0000, 32'h0,
             32'h0000_0000, 32'h0000_0077, 32'h0);
    prog_dec(3, 32'h0000_0000, 32'h2, 32'h2000_0000, 32'h0,
             32'h0000_0100, 32'h0000_0099, 32'h0);
    prog_dec(4, 32'h0000_0000, 32'h3, 32'h1000_0000, 32'h0,
             32'h0000_0132, 32'hA3A2_A1A0, 32'hA7A6_A5A4);
    prog_dec(6, 32'hF000_0000, 32'hFFFF_FFFF, 32'h1000_0000, 32'h0,
             32'h0000_0100, 32'h0000_006C, 32'h0);
    wr(0, 32'h7);

    for (int v = 0; v < NV; v++) begin
      look(VEC[v][72:9], VEC[v][8], VEC[v][7:0], $sformatf("vector %0d", v));
    end

    // R3: count below dec4 hides it
    wr(0, 32'h4);
    look(64'h0000_0003_0000_0400, 1'b0, 8'h00, "R3 count 4 hides dec4");
    // R3: oversized count saturates
    wr(0, 32'hF);
    look(64'h0000_0003_0000_0400, 1'b1, 8'hA1, "R3 count saturates");
    // R3: zero count
    wr(0, 32'h0);
    look(64'h0000_0001_0000_0000, 1'b0, 8'h00, "R3 count zero");
    wr(0, 32'h7);

    // R4: low bits of size word ignored
    wr(8 + 2, 32'h4FFF_FFFF);
    look(64'h0000_0001_4000_0000, 1'b1, 8'h5A, "R4 size low bits ignored");
    look(64'h0000_0001_3FFF_FF00, 1'b1, 8'h44, "R4 dec0 still covers end");

    // R11: unmapped words have no effect
    wr(7, 32'hFFFF_FFFF);
    wr(15, 32'hFFFF_FFFF);
    wr(72, 32'hFFFF_FFFF);
    wr(8 * 6 + 7, 32'hFFFF_FFFF);
    look(64'h0000_0001_0000_0300, 1'b1, 8'h44, "R11 unmapped writes ignored");
    look(64'h0000_0001_6000_0000, 1'b0, 8'h00, "R11 no new window");

    // R7: committing dec2 uncovers it
    wr(8 * 3 + 4, 32'h0000_0100);
    look(64'h0000_0002_0000_0000, 1'b1, 8'h77, "R7 dec2 now committed");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule